// File: doc/BRIEF.md
# ATM Misrouted Cell Capture Monitor

This block sits behind a connection look-up stage and inspects every cell header the stage presents. A cell is classed as misrouted when the look-up returned neither of its two validity flags, when its VCI exceeds the limit set for the look-up space it came from, or when that space has VPI checking switched on and any VPI bit that the space does not use is set. Only spaces enabled in a 16-bit select mask are watched.

The first misrouted cell from an enabled space is captured. The block keeps its 32-bit header and the 4-bit index of its look-up space, and raises a latched flag. Later misrouted cells leave the capture untouched until software writes the clear bit. That write produces a one-cycle clear pulse, which empties the capture and re-arms detection. Software reads the result through a 16-bit register port.

Header layout used for the checks: VPI field is bits 31:20 and VCI field is bits 19:4.

Top module: `atm_misroute_mon`

## Requirements
- R1: The select mask at 0142h resets to FFFFh and is read and written there. Bit k enables space k, and a cell from a space whose bit is 0 is never captured.
- R2: A valid cell with lut_a = 0 and lut_i = 0 from an enabled space is misrouted.
- R3: A valid cell is misrouted when its VCI (header bits 19:4) is strictly greater than the maximum configured for its space. A VCI equal to the maximum is in range.
- R4: When the VPI-check bit for the cell's space is 1, a cell is misrouted if its VPI (header bits 31:20) ANDed with that space's unused-bit mask is non-zero. When the check bit is 0, VPI bits are not checked.
- R5: A cell that meets no misroute condition, or is offered while cell_vld is 0, is not captured.
- R6: Only the first misrouted cell after reset or after a clear is captured. Later misrouted cells do not change the header or the space index held.
- R7: The latched flag is bit 1 of 0144h and resets to 0. A capture shows in the registers from the cycle after the clock edge that samples the cell.
- R8: Bits 7:4 of 0144h give the look-up space index of the captured cell.
- R9: 0146h reads captured header bits 31:16 and 0148h reads bits 15:0. Both read 0 after reset and after a clear.
- R10: A write to 0144h with data bit 0 = 1 raises an internal clear pulse for the one cycle after the write. At the end of that cycle the flag, the space index and the header are zero and detection is re-armed. A write with bit 0 = 0 has no effect.
- R11: A misrouted cell offered in the same cycle as the clear pulse is not captured.
- R12: Bit 0, bits 3:2 and bits 15:8 of 0144h read 0, and any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_vld | input | 1 | One cell header is presented this cycle |
| cell_hdr | input | 32 | Cell header word |
| cell_space | input | 4 | Look-up space the cell came from |
| lut_a | input | 1 | Look-up result flag A |
| lut_i | input | 1 | Look-up result flag I |
| cfg_vci_max | input | 256 | Per-space VCI maximum, 16 bits per space, space k at bits 16k+15:16k |
| cfg_vpi_chk | input | 16 | Per-space VPI-check enable |
| cfg_vpi_unused | input | 192 | Per-space unused-VPI-bit mask, 12 bits per space |
| reg_addr | input | 16 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_addr) |

## Verification
Reads are combinational, so register data is due in the same cycle as the address. A cell sampled at one edge shows in the registers from the next cycle. A clear written at one edge takes effect one edge later, when the pulse ends. The bench drives every input on the falling edge and checks read data one nanosecond after it, so each check sees the state left by the last rising edge. A cell that must meet the clear pulse is placed in the single cycle right after the clear write.

// File: rtl/atm_mon_pkg.sv
package atm_mon_pkg;
  localparam int HDR_W   = 32;
  localparam int VPI_W   = 12;
  localparam int VCI_W   = 16;
  localparam int VCI_LSB = 4;
  localparam int VPI_LSB = 20;
  localparam int REG_DW  = 16;
  localparam int REG_AW  = 16;

  localparam logic [REG_AW-1:0] ADDR_SEL  = 16'h0142;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 16'h0144;
  localparam logic [REG_AW-1:0] ADDR_HHI  = 16'h0146;
  localparam logic [REG_AW-1:0] ADDR_HLO  = 16'h0148;

  function automatic logic [VCI_W-1:0] hdr_vci(input logic [HDR_W-1:0] h);
    return h[VCI_LSB +: VCI_W];
  endfunction

  function automatic logic [VPI_W-1:0] hdr_vpi(input logic [HDR_W-1:0] h);
    return h[VPI_LSB +: VPI_W];
  endfunction

  function automatic logic vci_over(input logic [VCI_W-1:0] vci,
                                    input logic [VCI_W-1:0] lim);
    return vci > lim;
  endfunction

  function automatic logic vpi_bad(input logic [VPI_W-1:0] vpi,
                                   input logic [VPI_W-1:0] unused,
                                   input logic chk);
    return chk && ((vpi & unused) != '0);
  endfunction
endpackage

// File: rtl/misroute_classify.sv
module misroute_classify
  import atm_mon_pkg::*;
#(
  parameter int NSPACE  = 16,
  parameter int SPACE_W = 4
) (
  input  logic                     cell_vld,
  input  logic [VCI_W-1:0]         vci,
  input  logic [VPI_W-1:0]         vpi,
  input  logic [SPACE_W-1:0]       space,
  input  logic                     lut_a,
  input  logic                     lut_i,
  input  logic [NSPACE*VCI_W-1:0]  cfg_vci_max,
  input  logic [NSPACE-1:0]        cfg_vpi_chk,
  input  logic [NSPACE*VPI_W-1:0]  cfg_vpi_unused,
  input  logic [NSPACE-1:0]        sel_mask,
  output logic                     cond_ai,
  output logic                     cond_vci,
  output logic                     cond_vpi,
  output logic                     hit
);
  logic [VCI_W-1:0] lim_arr [NSPACE];
  logic [VPI_W-1:0] unu_arr [NSPACE];

  for (genvar k = 0; k < NSPACE; k++) begin : g_unpack
    assign lim_arr[k] = cfg_vci_max[k*VCI_W +: VCI_W];
    assign unu_arr[k] = cfg_vpi_unused[k*VPI_W +: VPI_W];
  end

  logic space_on;
  assign space_on = sel_mask[space];
  assign cond_ai  = !lut_a && !lut_i;
  assign cond_vci = vci_over(vci, lim_arr[space]);
  assign cond_vpi = vpi_bad(vpi, unu_arr[space], cfg_vpi_chk[space]);
  assign hit      = cell_vld && space_on && (cond_ai || cond_vci || cond_vpi);
endmodule

// File: rtl/capture_store.sv
module capture_store
  import atm_mon_pkg::*;
#(
  parameter int SPACE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic [HDR_W-1:0]   hdr,
  input  logic [SPACE_W-1:0] space,
  input  logic               clr_pulse,
  output logic               latched,
  output logic [HDR_W-1:0]   cap_hdr,
  output logic [SPACE_W-1:0] cap_space
);
  logic take;
  assign take = hit && !latched && !clr_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched   <= 1'b0;
      cap_hdr   <= '0;
      cap_space <= '0;
    end else if (clr_pulse) begin
      latched   <= 1'b0;
      cap_hdr   <= '0;
      cap_space <= '0;
    end else if (take) begin
      latched   <= 1'b1;
      cap_hdr   <= hdr;
      cap_space <= space;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !clr_pulse) |=> ($stable(cap_hdr) && $stable(cap_space) && latched));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (!latched && cap_hdr == '0 && cap_space == '0));

  assert_nohit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !$rose(latched));

  assert_clrwins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && hit) |=> !latched);
endmodule

// File: rtl/mon_regs.sv
module mon_regs
  import atm_mon_pkg::*;
#(
  parameter int NSPACE  = 16,
  parameter int SPACE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [REG_DW-1:0]  reg_wdata,
  input  logic               latched,
  input  logic [HDR_W-1:0]   cap_hdr,
  input  logic [SPACE_W-1:0] cap_space,
  output logic [NSPACE-1:0]  sel_mask,
  output logic               clr_pulse,
  output logic [REG_DW-1:0]  reg_rdata
);
  logic wr_sel, wr_clr;
  assign wr_sel = reg_wr && (reg_addr == ADDR_SEL);
  assign wr_clr = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_mask  <= '1;
      clr_pulse <= 1'b0;
    end else begin
      if (wr_sel) sel_mask <= reg_wdata[NSPACE-1:0];
      clr_pulse <= wr_clr;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_SEL:  reg_rdata[NSPACE-1:0] = sel_mask;
      ADDR_CTRL: begin
        reg_rdata[1]           = latched;
        reg_rdata[4 +: SPACE_W] = cap_space;
      end
      ADDR_HHI:  reg_rdata = cap_hdr[HDR_W-1:REG_DW];
      ADDR_HLO:  reg_rdata = cap_hdr[REG_DW-1:0];
      default:   reg_rdata = '0;
    endcase
  end

  assert_rsvd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_CTRL) |-> (reg_rdata[15:8] == '0 && reg_rdata[3:2] == '0 && !reg_rdata[0]));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> $past(reg_wr));
endmodule

// File: rtl/atm_misroute_mon.sv
module atm_misroute_mon
  import atm_mon_pkg::*;
#(
  parameter int NSPACE  = 16,
  parameter int SPACE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cell_vld,
  input  logic [31:0]              cell_hdr,
  input  logic [SPACE_W-1:0]       cell_space,
  input  logic                     lut_a,
  input  logic                     lut_i,
  input  logic [NSPACE*16-1:0]     cfg_vci_max,
  input  logic [NSPACE-1:0]        cfg_vpi_chk,
  input  logic [NSPACE*12-1:0]     cfg_vpi_unused,
  input  logic [15:0]              reg_addr,
  input  logic                     reg_wr,
  input  logic [15:0]              reg_wdata,
  output logic [15:0]              reg_rdata
);
  logic [NSPACE-1:0]  sel_mask;
  logic               clr_pulse;
  logic               cond_ai, cond_vci, cond_vpi, hit;
  logic               latched;
  logic [HDR_W-1:0]   cap_hdr;
  logic [SPACE_W-1:0] cap_space;

  misroute_classify #(.NSPACE(NSPACE), .SPACE_W(SPACE_W)) u_cls (
    .cell_vld(cell_vld), .vci(hdr_vci(cell_hdr)), .vpi(hdr_vpi(cell_hdr)),
    .space(cell_space), .lut_a(lut_a), .lut_i(lut_i),
    .cfg_vci_max(cfg_vci_max), .cfg_vpi_chk(cfg_vpi_chk),
    .cfg_vpi_unused(cfg_vpi_unused), .sel_mask(sel_mask),
    .cond_ai(cond_ai), .cond_vci(cond_vci), .cond_vpi(cond_vpi), .hit(hit));

  capture_store #(.SPACE_W(SPACE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .hit(hit), .hdr(cell_hdr), .space(cell_space),
    .clr_pulse(clr_pulse), .latched(latched), .cap_hdr(cap_hdr),
    .cap_space(cap_space));

  mon_regs #(.NSPACE(NSPACE), .SPACE_W(SPACE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .latched(latched), .cap_hdr(cap_hdr),
    .cap_space(cap_space), .sel_mask(sel_mask), .clr_pulse(clr_pulse),
    .reg_rdata(reg_rdata));

  assert_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_vld && !sel_mask[cell_space]) |=> !$rose(latched));

  assert_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched) |-> $past(cond_ai || cond_vci || cond_vpi));
endmodule

// File: tb/sim_atm_misroute_mon.sv
`timescale 1ns/1ps
module sim_atm_misroute_mon;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cell_vld = 1'b0;
  logic [31:0] cell_hdr = '0;
  logic [3:0] cell_space = '0;
  logic lut_a = 1'b1, lut_i = 1'b1;
  logic [255:0] cfg_vci_max;
  logic [15:0] cfg_vpi_chk;
  logic [191:0] cfg_vpi_unused;
  logic [15:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  always #2 clk = ~clk;

  atm_misroute_mon u0 (.*);

  typedef struct { logic [15:0] addr; logic [15:0] exp; string tag; } exp_t;
  exp_t sbq[$];
  int checks = 0, failures = 0;
  bit rd_req = 0, done = 0;

  // reference state
  logic [15:0] m_mask = 16'hFFFF;
  bit m_lat = 0;
  logic [31:0] m_hdr = '0;
  logic [3:0] m_sp = '0;

  function automatic bit ref_mis(logic [31:0] h, logic [3:0] s, bit a, bit i);
    bit r;
    r = (a == 0 && i == 0);
    if (h[19:4] > cfg_vci_max[s*16 +: 16]) r = 1;
    if (cfg_vpi_chk[s] && |(h[31:20] & cfg_vpi_unused[s*12 +: 12])) r = 1;
    return r;
  endfunction

  function automatic logic [15:0] ref_read(logic [15:0] a);
    case (a)
      16'h0142: return m_mask;
      16'h0144: return {8'h00, m_sp, 2'b00, m_lat, 1'b0};
      16'h0146: return m_hdr[31:16];
      16'h0148: return m_hdr[15:0];
      default:  return 16'h0000;
    endcase
  endfunction

  task automatic do_read(logic [15:0] a, string tag);
    exp_t e;
    @(negedge clk);
    reg_addr = a;
    e.addr = a; e.exp = ref_read(a); e.tag = tag;
    sbq.push_back(e);
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic do_write(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    if (a == 16'h0142) m_mask = d;
    if (a == 16'h0144 && d[0]) begin m_lat = 0; m_hdr = '0; m_sp = '0; end
  endtask

  task automatic send_cell(logic [31:0] h, logic [3:0] s, bit a, bit i, bit v);
    @(negedge clk);
    cell_vld = v; cell_hdr = h; cell_space = s; lut_a = a; lut_i = i;
    @(negedge clk);
    cell_vld = 0; lut_a = 1; lut_i = 1;
    if (v && m_mask[s] && !m_lat && ref_mis(h, s, a, i)) begin
      m_lat = 1; m_hdr = h; m_sp = s;
    end
  endtask

  task automatic read_all(string tag);
    do_read(16'h0144, tag);
    do_read(16'h0146, tag);
    do_read(16'h0148, tag);
  endtask

  // monitor: pops expected reads and compares mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rd_req && sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (reg_rdata !== e.exp) begin
          failures++;
          $display("FAIL %s addr=%h actual=%h expected=%h", e.tag, e.addr, reg_rdata, e.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) begin
      cfg_vci_max[k*16 +: 16] = 16'h0FFF;
      cfg_vpi_unused[k*12 +: 12] = 12'hF00;
    end
    cfg_vci_max[5*16 +: 16] = 16'h0020;
    cfg_vpi_chk = 16'h0080; // space 7 only
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state R1 R7 R9 R12
    do_read(16'h0142, "R1 reset mask");
    read_all("R7 R9 reset");
    do_read(16'h0150, "R12 unmapped");

    // R5: good cells and invalid strobe
    send_cell({12'h001, 16'h0100, 4'h0}, 4'd0, 1, 0, 1);
    send_cell({12'h001, 16'h0100, 4'h0}, 4'd1, 0, 0, 0);
    read_all("R5 no capture");

    // R2 R7 R8 R9: A=I=0 on space 3
    send_cell(32'h0123_4567 & 32'h000F_FFFF, 4'd3, 0, 0, 1);
    read_all("R2 R8 capture");

    // R6: later misroute ignored
    send_cell(32'h000A_BCD0, 4'd2, 0, 0, 1);
    read_all("R6 hold");

    // R10: write with bit0=0 no effect, then real clear
    do_write(16'h0144, 16'hFFFE);
    read_all("R10 no clear");
    do_write(16'h0144, 16'h0001);
    read_all("R10 cleared");

    // R3: VCI boundary on space 5 (max 0x20)
    send_cell({12'h000, 16'h0020, 4'h3}, 4'd5, 1, 0, 1);
    read_all("R3 equal in range");
    send_cell({12'h000, 16'h0021, 4'h3}, 4'd5, 1, 0, 1);
    read_all("R3 over range");
    do_write(16'h0144, 16'h0001);

    // R4: unused VPI bits, check off on space 6, on for space 7
    send_cell({12'h100, 16'h0005, 4'h0}, 4'd6, 0, 1, 1);
    read_all("R4 check off");
    send_cell({12'h0FF, 16'h0005, 4'h0}, 4'd7, 0, 1, 1);
    read_all("R4 used bits only");
    send_cell({12'h100, 16'h0005, 4'h0}, 4'd7, 0, 1, 1);
    read_all("R4 unused bit set");
    do_write(16'h0144, 16'h0001);

    // R1: disable space 9
    do_write(16'h0142, 16'hFDFF);
    do_read(16'h0142, "R1 mask write");
    send_cell(32'h0009_9990, 4'd9, 0, 0, 1);
    read_all("R1 masked space");
    send_cell(32'h000A_AAA0, 4'd10, 0, 0, 1);
    read_all("R1 enabled space");
    do_write(16'h0142, 16'hFFFF);
    do_write(16'h0144, 16'h0001);

    // R11: cell in the clear-pulse cycle is dropped
    send_cell(32'h000C_CCC0, 4'd12, 0, 0, 1);
    @(negedge clk);
    reg_addr = 16'h0144; reg_wdata = 16'h0001; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    cell_vld = 1; cell_hdr = 32'h000D_DDD0; cell_space = 4'd13; lut_a = 0; lut_i = 0;
    @(negedge clk);
    cell_vld = 0; lut_a = 1; lut_i = 1;
    m_lat = 0; m_hdr = '0; m_sp = '0;
    read_all("R11 clear wins");
    // R10 re-armed
    send_cell(32'h000E_EEE0, 4'd14, 0, 0, 1);
    read_all("R10 rearmed");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule